// File: doc/BRIEF.md
# Lock-Qualified DAC Soft-Mute Controller

This block sits between a digital audio receiver and a DAC's control register. It watches the receiver's loss-of-lock flag and a de-emphasis flag. It keeps the DAC's mute and de-emphasis controls in step with them by issuing writes to one DAC control register over a request/acknowledge port. The serial transport that carries those writes is outside the block.

When lock is lost, the DAC is muted at once. When lock comes back, the mute stays on until lock has held without a break for a qualification window. A single drop during that window starts the window again, as in a debouncer. Each unmute samples the de-emphasis flag and writes it into the same register. A change of that flag while audio is playing forces a mute, followed by an unmute in the new state. Every write rebuilds the whole register from state held inside the block, so neither field can overwrite the other.

Top module: `dac_mute_ctrl`

## Requirements
- R1: After reset, with the loss-of-lock input held high, no write request is raised. The DAC is taken to start out muted with de-emphasis off.
- R2: A raised `wr_req_o` stays high, with `wr_addr_o` and `wr_data_o` unchanged, until the cycle in which `wr_ack_i` is high. `wr_addr_o` always equals `REG_ADDR` (default 10).
- R3: When `unlock_i` rises while the DAC is unmuted and no write is outstanding, a write with bit 0 (mute) equal to 1 is requested within 4 clock cycles.
- R4: After `unlock_i` falls and stays low, an unmute write (bit 0 equal to 0) is requested no sooner than `QUAL_CYCLES` cycles and no later than `QUAL_CYCLES`+4 cycles after the fall.
- R5: If `unlock_i` rises again before the window ends, no unmute is requested. The full window is measured again from the next fall.
- R6: Each unmute write carries bit `DEEMPH_BIT` (default 1) equal to 1 when `deemph_n_i` is low (de-emphasis on), and 0 when it is high. The input is active-low, so a pulled-up, unconnected pin means off.
- R7: A change of `deemph_n_i` while the DAC is unmuted causes a mute write, then an unmute write carrying the new de-emphasis bit.
- R8: Every write carries both fields. A mute write repeats the de-emphasis bit last written, and every bit other than bit 0 and bit `DEEMPH_BIT` is 0.
- R9: A loss of lock that arrives while an unmute write is outstanding is held, and it leads to a mute write after that write is acknowledged.
- R10: A change of `deemph_n_i` while the DAC is muted requests no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| unlock_i | input | 1 | Receiver loss-of-lock flag, asynchronous, 1 = not locked |
| deemph_n_i | input | 1 | De-emphasis flag, asynchronous, active low |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | 8 | Target register address |
| wr_data_o | output | 8 | Full register value to write |
| wr_ack_i | input | 1 | Write completed; it ends the request |

## Verification
The bench builds the block with `QUAL_CYCLES` set to 20 instead of a value in the hundreds of milliseconds. This makes the complete qualify, restart and de-emphasis sequences short enough to run back to back. It also lets a lock glitch be placed a few cycles before the window ends, so the restart edge can be tested. The default `REG_ADDR` and `DEEMPH_BIT` are kept, so address and field positions are checked against the values that are actually used.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int REG_W = 8;

    // Control fields the block owns inside the DAC register
    typedef struct packed {
        logic deemph;   // 1 = de-emphasis on
        logic mute;     // 1 = muted
    } dac_ctl_t;

    localparam dac_ctl_t CTL_RESET = '{deemph: 1'b0, mute: 1'b1};

    // Build the full register image: mute at bit 0, de-emphasis at dbit
    function automatic logic [REG_W-1:0] pack_ctl(dac_ctl_t c, int dbit);
        logic [REG_W-1:0] v;
        v       = '0;
        v[0]    = c.mute;
        v[dbit] = c.deemph;
        return v;
    endfunction

endpackage

// File: rtl/dmc_sync.sv
module dmc_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= {WIDTH{RST_VAL}};
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= {WIDTH{RST_VAL}};
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dmc_lock_qual.sv
module dmc_lock_qual #(
    parameter int QUAL_CYCLES = 80_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic unlock_s,
    output logic qualified
);
    localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Any loss of lock restarts the window; the count saturates at the limit
    always_ff @(posedge clk) begin
        if (rst || unlock_s)   cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign qualified = (cnt_q == LIMIT);
endmodule

// File: rtl/dmc_writer.sv
module dmc_writer
    import dmc_pkg::*;
#(
    parameter int DEEMPH_BIT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qualified,
    input  logic             deemph_on,
    input  logic             wr_ack,
    output logic             wr_req,
    output logic [REG_W-1:0] wr_data
);
    dac_ctl_t cur_q;      // what the DAC holds
    dac_ctl_t pend_q;     // value of the write in flight
    logic     req_q;
    logic     seen_q;     // de-emphasis value last observed
    logic     remute_q;   // de-emphasis change awaiting a mute

    logic     dchg;
    logic     want_mute;
    logic     want_unmute;
    logic     done;

    assign dchg        = (deemph_on != seen_q);
    assign done        = req_q && wr_ack;
    assign want_mute   = !req_q && !cur_q.mute && (!qualified || remute_q);
    assign want_unmute = !req_q && cur_q.mute && qualified && !remute_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= CTL_RESET;
            pend_q   <= CTL_RESET;
            req_q    <= 1'b0;
            seen_q   <= 1'b0;
            remute_q <= 1'b0;
        end else begin
            seen_q <= deemph_on;
            if (dchg)
                remute_q <= 1'b1;
            else if (!req_q && cur_q.mute)
                remute_q <= 1'b0;

            if (done) begin
                req_q <= 1'b0;
                cur_q <= pend_q;
            end else if (want_mute) begin
                req_q  <= 1'b1;
                pend_q <= '{deemph: cur_q.deemph, mute: 1'b1};
            end else if (want_unmute) begin
                req_q  <= 1'b1;
                pend_q <= '{deemph: deemph_on, mute: 1'b0};
            end
        end
    end

    assign wr_req  = req_q;
    assign wr_data = pack_ctl(pend_q, DEEMPH_BIT);
endmodule

// File: rtl/dac_mute_ctrl.sv
module dac_mute_ctrl
    import dmc_pkg::*;
#(
    parameter int QUAL_CYCLES = 80_000_000,
    parameter int SYNC_STAGES = 2,
    parameter int REG_ADDR    = 10,
    parameter int DEEMPH_BIT  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unlock_i,
    input  logic             deemph_n_i,
    output logic             wr_req_o,
    output logic [REG_W-1:0] wr_addr_o,
    output logic [REG_W-1:0] wr_data_o,
    input  logic             wr_ack_i
);
    logic [1:0] raw_s;
    logic       unlock_s;
    logic       deemph_on_s;
    logic       lock_ok;

    // Both flags reset to their safe level: not locked, de-emphasis off
    dmc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({unlock_i, deemph_n_i}),
        .q   (raw_s)
    );

    assign unlock_s    = raw_s[1];
    assign deemph_on_s = !raw_s[0];

    dmc_lock_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .unlock_s  (unlock_s),
        .qualified (lock_ok)
    );

    dmc_writer #(.DEEMPH_BIT(DEEMPH_BIT)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .qualified (lock_ok),
        .deemph_on (deemph_on_s),
        .wr_ack    (wr_ack_i),
        .wr_req    (wr_req_o),
        .wr_data   (wr_data_o)
    );

    assign wr_addr_o = REG_W'(REG_ADDR);
endmodule

// File: rtl/dac_mute_ctrl_chk.sv
module dac_mute_ctrl_chk #(
    parameter int REG_ADDR   = 10,
    parameter int DEEMPH_BIT = 1
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_req,
    input logic       wr_ack,
    input logic [7:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       qualified,
    input logic       deemph_on
);
    localparam logic [7:0] USED = 8'h01 | (8'h01 << DEEMPH_BIT);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: no request in the cycle after reset
    always @(posedge clk)
        if (rst_d === 1'b1 && !rst)
            a_r1_idle_after_reset: assert (!wr_req);

    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        wr_req && !wr_ack |=> wr_req && $stable(wr_data));

    a_r2_fixed_addr: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> wr_addr == 8'(REG_ADDR));

    a_r8_spare_zero: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> (wr_data & ~USED) == 8'h00);

    a_r4_unmute_needs_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_req) && !wr_data[0] |-> $past(qualified));

    a_r6_unmute_deemph: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_req) && !wr_data[0] |-> wr_data[DEEMPH_BIT] == $past(deemph_on));
endmodule

bind dac_mute_ctrl dac_mute_ctrl_chk #(.REG_ADDR(REG_ADDR), .DEEMPH_BIT(DEEMPH_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req_o),
    .wr_ack    (wr_ack_i),
    .wr_addr   (wr_addr_o),
    .wr_data   (wr_data_o),
    .qualified (lock_ok),
    .deemph_on (deemph_on_s)
);

// File: tb/dac_mute_ctrl_test.sv
module dac_mute_ctrl_test;
    localparam int QUAL = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       unlock_i;
    logic       deemph_n_i;
    logic       wr_req_o;
    logic [7:0] wr_addr_o;
    logic [7:0] wr_data_o;
    logic       wr_ack_i;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dac_mute_ctrl #(.QUAL_CYCLES(QUAL)) uut (
        .clk        (clk),
        .rst        (rst),
        .unlock_i   (unlock_i),
        .deemph_n_i (deemph_n_i),
        .wr_req_o   (wr_req_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .wr_ack_i   (wr_ack_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges until a request is seen; 0 if none within max
    task automatic wait_req(input int max, output int n);
        n = 0;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (wr_req_o) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic ack();
        wr_ack_i = 1'b1;
        @(negedge clk);
        wr_ack_i = 1'b0;
    endtask

    task automatic t_reset();
        int n;
        wait_req(10, n);
        chk(n == 0, "R1 no request after reset", n, 0);
    endtask

    task automatic t_qualify();
        int n;
        logic [7:0] d0;
        unlock_i = 1'b0;
        wait_req(QUAL + 10, n);
        chk(n > QUAL && n <= QUAL + 4, "R4 unmute after window", n, QUAL + 3);
        chk(wr_data_o[0] == 1'b0, "R4 unmute bit0", wr_data_o[0], 0);
        chk(wr_data_o[1] == 1'b0, "R6 deemph off when pin high", wr_data_o[1], 0);
        chk(wr_addr_o == 8'd10, "R2 address", wr_addr_o, 10);
        chk((wr_data_o & 8'hFC) == 0, "R8 spare bits", wr_data_o, wr_data_o & 8'h03);
        d0 = wr_data_o;
        repeat (3) @(negedge clk);
        chk(wr_req_o && wr_data_o == d0, "R2 held until ack", wr_data_o, d0);
        ack();
        chk(!wr_req_o, "R2 drop on ack", wr_req_o, 0);
    endtask

    task automatic t_loss(input bit exp_de);
        int n;
        unlock_i = 1'b1;
        wait_req(8, n);
        chk(n >= 1 && n <= 4, "R3 mute latency", n, 4);
        chk(wr_data_o[0] == 1'b1, "R3 mute bit0", wr_data_o[0], 1);
        chk(wr_data_o[1] == exp_de, "R8 mute keeps deemph", wr_data_o[1], exp_de);
        ack();
    endtask

    task automatic t_restart();
        int n;
        unlock_i = 1'b0;
        repeat (QUAL - 5) @(negedge clk);
        unlock_i = 1'b1;
        wait_req(2, n);
        chk(n == 0, "R5 no write during glitch", n, 0);
        unlock_i = 1'b0;
        wait_req(QUAL + 10, n);
        chk(n > QUAL && n <= QUAL + 4, "R5 window restarted", n, QUAL + 3);
        chk(wr_data_o[0] == 1'b0, "R5 unmute after restart", wr_data_o[0], 0);
        ack();
    endtask

    task automatic t_deemph_live();
        int n;
        deemph_n_i = 1'b0;
        wait_req(8, n);
        chk(n != 0 && wr_data_o[0] == 1'b1, "R7 remute on deemph change", wr_data_o[0], 1);
        chk(wr_data_o[1] == 1'b0, "R8 remute keeps old deemph", wr_data_o[1], 0);
        ack();
        wait_req(8, n);
        chk(n != 0 && wr_data_o[0] == 1'b0, "R7 unmute after remute", wr_data_o[0], 0);
        chk(wr_data_o[1] == 1'b1, "R6 deemph on when pin low", wr_data_o[1], 1);
        ack();
    endtask

    task automatic t_deemph_muted();
        int n;
        t_loss(1'b1);
        deemph_n_i = 1'b1;
        wait_req(10, n);
        chk(n == 0, "R10 no write while muted", n, 0);
        unlock_i = 1'b0;
        wait_req(QUAL + 10, n);
        chk(n != 0 && wr_data_o[1] == 1'b0, "R6 unmute samples new deemph", wr_data_o[1], 0);
        ack();
    endtask

    task automatic t_busy();
        int n;
        t_loss(1'b0);
        unlock_i = 1'b0;
        wait_req(QUAL + 10, n);
        chk(n != 0 && wr_data_o[0] == 1'b0, "R9 unmute pending", wr_data_o[0], 0);
        unlock_i = 1'b1;
        repeat (8) @(negedge clk);
        chk(wr_req_o && wr_data_o[0] == 1'b0, "R2 held while lock lost", wr_data_o[0], 0);
        ack();
        wait_req(8, n);
        chk(n != 0 && wr_data_o[0] == 1'b1, "R9 mute after ack", wr_data_o[0], 1);
        ack();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst        = 1'b1;
        unlock_i   = 1'b1;
        deemph_n_i = 1'b1;
        wr_ack_i   = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_qualify();
        t_loss(1'b0);
        t_restart();
        t_deemph_live();
        t_deemph_muted();
        t_busy();
        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule